// File: doc/BRIEF.md
# Segment Privilege Check Unit

This block decides whether a segment register load or a far control transfer may go ahead. It is given the current privilege level, the requested privilege level carried by the selector, the selector index, the descriptor-table limit and the decoded fields of the target descriptor: its kind, attribute bits, privilege level, present flag and limit. When the target is a call gate, the bench-side fetch logic also supplies the gate's stored selector and offset and the decoded fields of the code descriptor that the gate names. Fetching descriptors from memory, task switching and the stack switch on a privilege change are done elsewhere.

One cycle after a request, the block returns either an accept, with the privilege level, selector index, selector RPL and offset to commit, or a fault code. A faulted request commits nothing: every commit field reads zero. Privilege levels run from 0, the most privileged, to 3, the least privileged, and are compared numerically.

Encodings used throughout: operation 0 = data segment load, 1 = stack segment load, 2 = far jump, 3 = far call. Descriptor kind 0 = data, 1 = code, 2 = call gate, 3 = other system. Attribute bit 0 = writable (data) or readable (code); attribute bit 1 = conforming (code). Fault code 0 = none, 1 = limit, 2 = not present, 3 = type, 4 = privilege, 5 = gate misuse.

Top module: `seg_priv_check`

## Requirements
- R1: Each cycle with req_valid_i high produces done_o high on the next cycle only; when no request was presented, done_o, accept_o, fault_code_o and all commit outputs are zero, including right after reset.
- R2: A selector index greater than the table limit gives fault 1 ahead of every other check; an index equal to the limit passes this check.
- R3: A data load (operation 0) accepts a data descriptor or a readable code descriptor (attribute bit 0 set); an execute-only code descriptor, a call gate or another system descriptor gives fault 3.
- R4: A descriptor that passes the type check but is not present gives fault 2; a type failure is reported ahead of a missing present flag.
- R5: A data load requires DPL to be numerically at least the larger of CPL and the selector's RPL, else fault 4; on accept the CPL is unchanged and the supplied index and RPL are committed with offset zero.
- R6: A stack load (operation 1) requires a writable data descriptor (kind 0, attribute bit 0 set), else fault 3, and DPL equal to CPL, else fault 4.
- R7: A far jump or call to a direct target requires a code descriptor (else fault 3), present (else fault 2), DPL equal to CPL for a non-conforming segment or DPL at most CPL for a conforming one (else fault 4), and the offset at most the segment limit (else fault 1).
- R8: After an accepted far transfer the new CPL is the target DPL for a non-conforming segment and the caller's CPL for a conforming one, and the committed RPL equals that new CPL whatever RPL was supplied.
- R9: A far jump that names a call gate gives fault 5.
- R10: A far call through a gate checks, in order: gate DPL at least CPL (fault 4), gate present (fault 2), the gate's selector index within the table limit (fault 1), the gate target is code (fault 3), target present (fault 2), target DPL at most CPL (fault 4), gate offset within the target limit (fault 1).
- R11: An accepted call through a gate commits the gate's stored selector index and offset, ignoring those supplied by the caller.
- R12: On any fault, accept_o is low and new_cpl_o, commit_index_o, commit_rpl_o and commit_offset_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| op_i | input | 2 | Operation code |
| cpl_i | input | 2 | Current privilege level |
| sel_rpl_i | input | 2 | Requested privilege level from the selector |
| sel_index_i | input | IDX_W | Selector index |
| tbl_limit_i | input | IDX_W | Highest valid index of the descriptor table |
| desc_kind_i | input | 2 | Descriptor kind |
| desc_attr_i | input | 2 | Descriptor attribute bits |
| desc_dpl_i | input | 2 | Descriptor privilege level |
| desc_present_i | input | 1 | Descriptor present flag |
| desc_limit_i | input | OFF_W | Segment limit |
| offset_i | input | OFF_W | Offset supplied by the caller |
| gate_index_i | input | IDX_W | Selector index stored in the gate |
| gate_offset_i | input | OFF_W | Offset stored in the gate |
| gtgt_kind_i | input | 2 | Kind of the gate's target descriptor |
| gtgt_attr_i | input | 2 | Attribute bits of the gate's target |
| gtgt_dpl_i | input | 2 | Privilege level of the gate's target |
| gtgt_present_i | input | 1 | Present flag of the gate's target |
| gtgt_limit_i | input | OFF_W | Limit of the gate's target |
| done_o | output | 1 | Result valid |
| accept_o | output | 1 | Request allowed |
| fault_code_o | output | 3 | Fault code, zero on accept |
| new_cpl_o | output | 2 | Privilege level to commit |
| commit_index_o | output | IDX_W | Selector index to commit |
| commit_rpl_o | output | 2 | Selector RPL to commit |
| commit_offset_o | output | OFF_W | Offset to commit |

## Verification
Every result is due exactly one clock edge after the cycle in which req_valid_i was high, and is gone one edge later. The bench drives a request on a falling edge, lets one rising edge pass, and compares all outputs at the next falling edge; it then drops the request and checks at the following falling edge that the result has cleared. Back-to-back requests are checked the same way, one result per falling edge.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;
  typedef enum logic [1:0] {
    OP_LOAD_DATA  = 2'd0,
    OP_LOAD_STACK = 2'd1,
    OP_FAR_JMP    = 2'd2,
    OP_FAR_CALL   = 2'd3
  } seg_op_e;

  typedef enum logic [1:0] {
    KIND_DATA = 2'd0,
    KIND_CODE = 2'd1,
    KIND_GATE = 2'd2,
    KIND_SYS  = 2'd3
  } desc_kind_e;

  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_LIMIT  = 3'd1,
    FLT_ABSENT = 3'd2,
    FLT_TYPE   = 3'd3,
    FLT_PRIV   = 3'd4,
    FLT_GATE   = 3'd5
  } fault_e;

  localparam int unsigned ATTR_RW   = 0;
  localparam int unsigned ATTR_CONF = 1;
endpackage

// File: rtl/seg_chk_load.sv
module seg_chk_load
  import seg_chk_pkg::*;
(
  input  logic       is_stack_i,
  input  logic       idx_ok_i,
  input  logic [1:0] cpl_i,
  input  logic [1:0] rpl_i,
  input  logic [1:0] kind_i,
  input  logic [1:0] attr_i,
  input  logic [1:0] dpl_i,
  input  logic       present_i,
  output logic [2:0] fault_o
);
  logic [1:0] eff_pl;
  logic       type_ok;
  logic       priv_ok;
  fault_e     fault;

  always_comb begin
    eff_pl = (cpl_i > rpl_i) ? cpl_i : rpl_i;
    if (is_stack_i) begin
      type_ok = (kind_i == KIND_DATA) && attr_i[ATTR_RW];
      priv_ok = (dpl_i == cpl_i);
    end else begin
      type_ok = (kind_i == KIND_DATA) || ((kind_i == KIND_CODE) && attr_i[ATTR_RW]);
      priv_ok = (dpl_i >= eff_pl);
    end
    if (!idx_ok_i)       fault = FLT_LIMIT;
    else if (!type_ok)   fault = FLT_TYPE;
    else if (!present_i) fault = FLT_ABSENT;
    else if (!priv_ok)   fault = FLT_PRIV;
    else                 fault = FLT_NONE;
    fault_o = fault;
  end
endmodule

// File: rtl/seg_chk_xfer.sv
module seg_chk_xfer
  import seg_chk_pkg::*;
#(
  parameter int unsigned IDX_W = 13,
  parameter int unsigned OFF_W = 32
) (
  input  logic             is_call_i,
  input  logic             idx_ok_i,
  input  logic [1:0]       cpl_i,
  input  logic [IDX_W-1:0] tbl_limit_i,
  input  logic [IDX_W-1:0] sel_index_i,
  input  logic [1:0]       kind_i,
  input  logic [1:0]       attr_i,
  input  logic [1:0]       dpl_i,
  input  logic             present_i,
  input  logic [OFF_W-1:0] limit_i,
  input  logic [OFF_W-1:0] offset_i,
  input  logic [IDX_W-1:0] gate_index_i,
  input  logic [OFF_W-1:0] gate_offset_i,
  input  logic [1:0]       tgt_kind_i,
  input  logic [1:0]       tgt_attr_i,
  input  logic [1:0]       tgt_dpl_i,
  input  logic             tgt_present_i,
  input  logic [OFF_W-1:0] tgt_limit_i,
  output logic [2:0]       fault_o,
  output logic [1:0]       new_cpl_o,
  output logic [IDX_W-1:0] index_o,
  output logic [OFF_W-1:0] offset_o
);
  logic   via_gate;
  logic   direct_priv_ok;
  fault_e fault;

  assign via_gate = (kind_i == KIND_GATE);
  assign direct_priv_ok = attr_i[ATTR_CONF] ? (dpl_i <= cpl_i) : (dpl_i == cpl_i);

  always_comb begin
    if (!idx_ok_i)                         fault = FLT_LIMIT;
    else if (via_gate) begin
      if (!is_call_i)                      fault = FLT_GATE;
      else if (dpl_i < cpl_i)              fault = FLT_PRIV;
      else if (!present_i)                 fault = FLT_ABSENT;
      else if (gate_index_i > tbl_limit_i) fault = FLT_LIMIT;
      else if (tgt_kind_i != KIND_CODE)    fault = FLT_TYPE;
      else if (!tgt_present_i)             fault = FLT_ABSENT;
      else if (tgt_dpl_i > cpl_i)          fault = FLT_PRIV;
      else if (gate_offset_i > tgt_limit_i) fault = FLT_LIMIT;
      else                                 fault = FLT_NONE;
    end
    else if (kind_i != KIND_CODE)          fault = FLT_TYPE;
    else if (!present_i)                   fault = FLT_ABSENT;
    else if (!direct_priv_ok)              fault = FLT_PRIV;
    else if (offset_i > limit_i)           fault = FLT_LIMIT;
    else                                   fault = FLT_NONE;
    fault_o = fault;
  end

  always_comb begin
    if (via_gate) begin
      new_cpl_o = tgt_attr_i[ATTR_CONF] ? cpl_i : tgt_dpl_i;
      index_o   = gate_index_i;
      offset_o  = gate_offset_i;
    end else begin
      new_cpl_o = attr_i[ATTR_CONF] ? cpl_i : dpl_i;
      index_o   = sel_index_i;
      offset_o  = offset_i;
    end
  end
endmodule

// File: rtl/seg_priv_check.sv
module seg_priv_check
  import seg_chk_pkg::*;
#(
  parameter int unsigned IDX_W = 13,
  parameter int unsigned OFF_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [1:0]       op_i,
  input  logic [1:0]       cpl_i,
  input  logic [1:0]       sel_rpl_i,
  input  logic [IDX_W-1:0] sel_index_i,
  input  logic [IDX_W-1:0] tbl_limit_i,
  input  logic [1:0]       desc_kind_i,
  input  logic [1:0]       desc_attr_i,
  input  logic [1:0]       desc_dpl_i,
  input  logic             desc_present_i,
  input  logic [OFF_W-1:0] desc_limit_i,
  input  logic [OFF_W-1:0] offset_i,
  input  logic [IDX_W-1:0] gate_index_i,
  input  logic [OFF_W-1:0] gate_offset_i,
  input  logic [1:0]       gtgt_kind_i,
  input  logic [1:0]       gtgt_attr_i,
  input  logic [1:0]       gtgt_dpl_i,
  input  logic             gtgt_present_i,
  input  logic [OFF_W-1:0] gtgt_limit_i,
  output logic             done_o,
  output logic             accept_o,
  output logic [2:0]       fault_code_o,
  output logic [1:0]       new_cpl_o,
  output logic [IDX_W-1:0] commit_index_o,
  output logic [1:0]       commit_rpl_o,
  output logic [OFF_W-1:0] commit_offset_o
);
  seg_op_e          op;
  logic             is_xfer;
  logic             idx_ok;
  logic [2:0]       load_fault, xfer_fault, fault_d;
  logic [1:0]       xfer_cpl, cpl_d, rpl_d;
  logic [IDX_W-1:0] xfer_index, index_d;
  logic [OFF_W-1:0] xfer_offset, offset_d;

  assign op      = seg_op_e'(op_i);
  assign is_xfer = (op == OP_FAR_JMP) || (op == OP_FAR_CALL);
  assign idx_ok  = (sel_index_i <= tbl_limit_i);

  seg_chk_load u_load (
    .is_stack_i (op == OP_LOAD_STACK),
    .idx_ok_i   (idx_ok),
    .cpl_i      (cpl_i),
    .rpl_i      (sel_rpl_i),
    .kind_i     (desc_kind_i),
    .attr_i     (desc_attr_i),
    .dpl_i      (desc_dpl_i),
    .present_i  (desc_present_i),
    .fault_o    (load_fault)
  );

  seg_chk_xfer #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_xfer (
    .is_call_i     (op == OP_FAR_CALL),
    .idx_ok_i      (idx_ok),
    .cpl_i         (cpl_i),
    .tbl_limit_i   (tbl_limit_i),
    .sel_index_i   (sel_index_i),
    .kind_i        (desc_kind_i),
    .attr_i        (desc_attr_i),
    .dpl_i         (desc_dpl_i),
    .present_i     (desc_present_i),
    .limit_i       (desc_limit_i),
    .offset_i      (offset_i),
    .gate_index_i  (gate_index_i),
    .gate_offset_i (gate_offset_i),
    .tgt_kind_i    (gtgt_kind_i),
    .tgt_attr_i    (gtgt_attr_i),
    .tgt_dpl_i     (gtgt_dpl_i),
    .tgt_present_i (gtgt_present_i),
    .tgt_limit_i   (gtgt_limit_i),
    .fault_o       (xfer_fault),
    .new_cpl_o     (xfer_cpl),
    .index_o       (xfer_index),
    .offset_o      (xfer_offset)
  );

  // rpl of a code selector follows the new cpl
  always_comb begin
    if (is_xfer) begin
      fault_d  = xfer_fault;
      cpl_d    = xfer_cpl;
      rpl_d    = xfer_cpl;
      index_d  = xfer_index;
      offset_d = xfer_offset;
    end else begin
      fault_d  = load_fault;
      cpl_d    = cpl_i;
      rpl_d    = sel_rpl_i;
      index_d  = sel_index_i;
      offset_d = '0;
    end
  end

  logic             done_q;
  logic             xfer_q, stack_q;
  logic [2:0]       fault_q;
  logic [1:0]       cpl_q, rpl_q;
  logic [IDX_W-1:0] index_q;
  logic [OFF_W-1:0] offset_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q   <= 1'b0;
      xfer_q   <= 1'b0;
      stack_q  <= 1'b0;
      fault_q  <= '0;
      cpl_q    <= '0;
      rpl_q    <= '0;
      index_q  <= '0;
      offset_q <= '0;
    end else begin
      done_q  <= req_valid_i;
      xfer_q  <= req_valid_i && is_xfer;
      stack_q <= req_valid_i && (op == OP_LOAD_STACK);
      fault_q <= req_valid_i ? fault_d : '0;
      if (req_valid_i && (fault_d == FLT_NONE)) begin
        cpl_q    <= cpl_d;
        rpl_q    <= rpl_d;
        index_q  <= index_d;
        offset_q <= offset_d;
      end else begin
        cpl_q    <= '0;
        rpl_q    <= '0;
        index_q  <= '0;
        offset_q <= '0;
      end
    end
  end

  assign done_o          = done_q;
  assign accept_o        = done_q && (fault_q == FLT_NONE);
  assign fault_code_o    = fault_q;
  assign new_cpl_o       = cpl_q;
  assign commit_rpl_o    = rpl_q;
  assign commit_index_o  = index_q;
  assign commit_offset_o = offset_q;

  assert_done_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> done_o);
  assert_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!done_o && !accept_o && fault_code_o == 3'd0));
  assert_clean_fault_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_code_o != 3'd0) |-> (!accept_o && new_cpl_o == 2'd0 && commit_rpl_o == 2'd0
                               && commit_index_o == '0 && commit_offset_o == '0));
  assert_cpl_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> (new_cpl_o <= $past(cpl_i)));
  assert_rpl_forced_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && xfer_q) |-> (commit_rpl_o == new_cpl_o));
  assert_stack_dpl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && stack_q) |-> ($past(desc_dpl_i) == $past(cpl_i)));
endmodule

// File: tb/seg_priv_check_tb.sv
module seg_priv_check_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W = 13;
  localparam int OFF_W = 32;

  typedef struct packed {
    logic [1:0] op, cpl, rpl;
    logic [12:0] idx, tlim;
    logic [1:0] kind, attr, dpl;
    logic pres;
    logic [31:0] lim, off;
    logic [12:0] gidx;
    logic [31:0] goff;
    logic [1:0] tkind, tattr, tdpl;
    logic tpres;
    logic [31:0] tlim2;
    logic [3:0] rq;
    logic [2:0] ef;
    logic [1:0] ecpl;
    logic [12:0] eidx;
    logic [1:0] erpl;
    logic [31:0] eoff;
  } vec_t;

  localparam int NV = 30;
  // op,cpl,rpl,idx,tlim,kind,attr,dpl,pres,lim,off,gidx,goff,tkind,tattr,tdpl,tpres,tlim2,req,fault,cpl,idx,rpl,off
  localparam vec_t VECS [NV] = '{
    '{0,1,2, 5,20,0,1,2,1,'hFFF,'h100, 9,'h40,1,0,0,1,'hFF, 5,0,1, 5,2,0},      // R5 accept
    '{0,1,2, 5,20,0,1,1,1,'hFFF,'h100, 9,'h40,1,0,0,1,'hFF, 5,4,0, 0,0,0},      // R5 rpl dominates
    '{0,3,0, 5,20,0,1,2,1,'hFFF,'h100, 9,'h40,1,0,0,1,'hFF, 5,4,0, 0,0,0},      // R5 cpl dominates
    '{0,0,0,21,20,0,1,3,0,'hFFF,'h100, 9,'h40,1,0,0,1,'hFF, 2,1,0, 0,0,0},      // R2 over limit
    '{0,0,0,20,20,0,0,0,1,'hFFF,'h100, 9,'h40,1,0,0,1,'hFF, 2,0,0,20,0,0},      // R2 at limit
    '{0,0,0, 5,20,1,0,3,1,'hFFF,'h100, 9,'h40,1,0,0,1,'hFF, 3,3,0, 0,0,0},      // R3 execute-only
    '{0,0,0, 5,20,1,1,3,1,'hFFF,'h100, 9,'h40,1,0,0,1,'hFF, 3,0,0, 5,0,0},      // R3 readable code
    '{0,0,0, 5,20,2,0,3,1,'hFFF,'h100, 9,'h40,1,0,0,1,'hFF, 3,3,0, 0,0,0},      // R3 gate in data reg
    '{0,0,0, 5,20,0,1,3,0,'hFFF,'h100, 9,'h40,1,0,0,1,'hFF, 4,2,0, 0,0,0},      // R4 absent
    '{0,0,0, 5,20,1,0,3,0,'hFFF,'h100, 9,'h40,1,0,0,1,'hFF, 4,3,0, 0,0,0},      // R4 type first
    '{1,2,2, 5,20,0,1,2,1,'hFFF,'h100, 9,'h40,1,0,0,1,'hFF, 6,0,2, 5,2,0},      // R6 accept
    '{1,2,2, 5,20,0,0,2,1,'hFFF,'h100, 9,'h40,1,0,0,1,'hFF, 6,3,0, 0,0,0},      // R6 read-only
    '{1,2,2, 5,20,0,1,3,1,'hFFF,'h100, 9,'h40,1,0,0,1,'hFF, 6,4,0, 0,0,0},      // R6 dpl mismatch
    '{2,1,3, 5,20,1,0,1,1,'hFFF,'h100, 9,'h40,1,0,0,1,'hFF, 8,0,1, 5,1,'h100},  // R8 rpl forced
    '{2,1,1, 5,20,1,0,0,1,'hFFF,'h100, 9,'h40,1,0,0,1,'hFF, 7,4,0, 0,0,0},      // R7 nonconf dpl
    '{3,2,0, 5,20,1,2,0,1,'hFFF,'h100, 9,'h40,1,0,0,1,'hFF, 8,0,2, 5,2,'h100},  // R8 conforming
    '{3,2,2, 5,20,1,2,3,1,'hFFF,'h100, 9,'h40,1,0,0,1,'hFF, 7,4,0, 0,0,0},      // R7 conforming dpl
    '{2,0,0, 5,20,1,0,0,1,'hFFF,'h1000,9,'h40,1,0,0,1,'hFF, 7,1,0, 0,0,0},      // R7 offset over
    '{2,0,0, 5,20,1,0,0,1,'hFFF,'hFFF, 9,'h40,1,0,0,1,'hFF, 7,0,0, 5,0,'hFFF},  // R7 offset at limit
    '{3,0,0, 5,20,0,1,0,1,'hFFF,'h100, 9,'h40,1,0,0,1,'hFF, 7,3,0, 0,0,0},      // R7 data target
    '{2,0,0, 5,20,2,0,3,1,'hFFF,'h100, 9,'h40,1,0,0,1,'hFF, 9,5,0, 0,0,0},      // R9 jmp via gate
    '{3,3,3, 5,20,2,0,3,1,'hFFF,'h777, 9,'h40,1,0,0,1,'hFF,11,0,0, 9,0,'h40},   // R11 gate call
    '{3,3,3, 5,20,2,0,2,1,'hFFF,'h100, 9,'h40,1,0,0,1,'hFF,10,4,0, 0,0,0},      // R10 gate dpl
    '{3,3,3, 5,20,2,0,3,0,'hFFF,'h100, 9,'h40,1,0,0,1,'hFF,10,2,0, 0,0,0},      // R10 gate absent
    '{3,3,3, 5,20,2,0,3,1,'hFFF,'h100,30,'h40,1,0,0,1,'hFF,10,1,0, 0,0,0},      // R10 gate index
    '{3,3,3, 5,20,2,0,3,1,'hFFF,'h100, 9,'h40,0,0,0,1,'hFF,10,3,0, 0,0,0},      // R10 target type
    '{3,3,3, 5,20,2,0,3,1,'hFFF,'h100, 9,'h40,1,0,0,0,'hFF,10,2,0, 0,0,0},      // R10 target absent
    '{3,1,1, 5,20,2,0,3,1,'hFFF,'h100, 9,'h40,1,0,3,1,'hFF,10,4,0, 0,0,0},      // R10 target dpl
    '{3,3,3, 5,20,2,0,3,1,'hFFF,'h100, 9,'h100,1,0,0,1,'hFF,10,1,0,0,0,0},      // R10 gate offset
    '{3,3,3, 5,20,2,0,3,1,'hFFF,'h100, 9,'h40,1,2,0,1,'hFF,11,0,3, 9,3,'h40}    // R11 conforming target
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid;
  logic [1:0] op, cpl, rpl, kind, attr, dpl, tkind, tattr, tdpl;
  logic [IDX_W-1:0] idx, tlim, gidx;
  logic pres, tpres;
  logic [OFF_W-1:0] lim, off, goff, tlim2;
  logic done, accept;
  logic [2:0] fault;
  logic [1:0] ncpl, crpl;
  logic [IDX_W-1:0] cidx;
  logic [OFF_W-1:0] coff;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_priv_check #(.IDX_W(IDX_W), .OFF_W(OFF_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .op_i(op), .cpl_i(cpl),
    .sel_rpl_i(rpl), .sel_index_i(idx), .tbl_limit_i(tlim), .desc_kind_i(kind),
    .desc_attr_i(attr), .desc_dpl_i(dpl), .desc_present_i(pres), .desc_limit_i(lim),
    .offset_i(off), .gate_index_i(gidx), .gate_offset_i(goff), .gtgt_kind_i(tkind),
    .gtgt_attr_i(tattr), .gtgt_dpl_i(tdpl), .gtgt_present_i(tpres), .gtgt_limit_i(tlim2),
    .done_o(done), .accept_o(accept), .fault_code_o(fault), .new_cpl_o(ncpl),
    .commit_index_o(cidx), .commit_rpl_o(crpl), .commit_offset_o(coff)
  );

  task automatic drive(input vec_t v);
    op = v.op; cpl = v.cpl; rpl = v.rpl; idx = v.idx; tlim = v.tlim;
    kind = v.kind; attr = v.attr; dpl = v.dpl; pres = v.pres; lim = v.lim; off = v.off;
    gidx = v.gidx; goff = v.goff; tkind = v.tkind; tattr = v.tattr; tdpl = v.tdpl;
    tpres = v.tpres; tlim2 = v.tlim2;
  endtask

  task automatic check_result(input vec_t v, input string tag);
    logic exp_acc;
    exp_acc = (v.ef == 3'd0);
    checks++;
    if (!done || accept !== exp_acc || fault !== v.ef || ncpl !== v.ecpl || cidx !== v.eidx
        || crpl !== v.erpl || coff !== v.eoff) begin
      errors++;
      $display("FAIL %s R%0d: got done=%0b acc=%0b flt=%0d cpl=%0d idx=%0d rpl=%0d off=%0h, expected done=1 acc=%0b flt=%0d cpl=%0d idx=%0d rpl=%0d off=%0h",
               tag, v.rq, done, accept, fault, ncpl, cidx, crpl, coff,
               exp_acc, v.ef, v.ecpl, v.eidx, v.erpl, v.eoff);
    end
  endtask

  task automatic check_idle(input string tag);
    checks++;
    if (done || accept || fault != 0 || ncpl != 0 || cidx != 0 || crpl != 0 || coff != 0) begin
      errors++;
      $display("FAIL %s R1: got done=%0b acc=%0b flt=%0d cpl=%0d idx=%0d rpl=%0d off=%0h, expected all zero",
               tag, done, accept, fault, ncpl, cidx, crpl, coff);
    end
  endtask

  initial begin
    req_valid = 1'b0;
    drive(VECS[0]);
    repeat (2) @(negedge clk);
    check_idle("reset R1");
    rst_ni = 1'b1;
    @(negedge clk);
    check_idle("after reset R1");

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      req_valid = 1'b1;
      @(negedge clk);
      check_result(VECS[i], "vector");
      req_valid = 1'b0;
      @(negedge clk);
      check_idle("single pulse R1");
    end

    // back-to-back: accept then fault, one result per cycle (R1, R12)
    drive(VECS[0]);
    req_valid = 1'b1;
    @(negedge clk);
    check_result(VECS[0], "b2b first R1");
    drive(VECS[1]);
    @(negedge clk);
    check_result(VECS[1], "b2b fault clears commit R12");
    drive(VECS[21]);
    @(negedge clk);
    check_result(VECS[21], "b2b gate after fault R11");
    req_valid = 1'b0;
    @(negedge clk);
    check_idle("b2b end R1");

    finished = 1;
  end

  initial begin
    for (int c = 0; c < 5000 && !finished; c++) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1: got no completion, expected completion within 5000 cycles");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule